// File: doc/BRIEF.md
# Five-Channel Hit Merger with Pileup Flags

This block combines the discriminator pulses of several pixel channels onto one shared hit line. A time-measurement stage downstream sees both edges of that line. The first channel to rise while the merger is idle becomes the owner of the hit. The merged line then follows the owner's pulse level, delayed by a fixed number of clocks. A one-hot address vector records which channel or channels own the hit. Any other channel that starts a pulse while that hit is being handled is noted in a pileup vector and is not forwarded as a new hit.

The asynchronous inputs are oversampled in the block's clock domain. Each channel passes through the same synchroniser depth, so rising and falling edges are delayed equally on every channel. A read-out controller closes each transaction through two controls. It raises the block input after the hit has ended and lowers it once the hit data has been parallel-loaded. It pulses the pileup-clear input to empty the pileup vector. The pileup window opens one clock after a hit starts and stays open until the block input is released. The block input alone decides when the merger re-arms, and that is a separate matter from when pileup is recorded.

Top module: `hit_merge_arbiter`

## Requirements
- R1: While reset is asserted and just after it, `hit_o`, `addr_o` and `pileup_o` are all zero.
- R2: A rising edge on any channel while the merger is idle and `block_i` is low drives `hit_o` high exactly SYNC_STAGES+1 clocks after the input changed. `hit_o` falls exactly SYNC_STAGES+1 clocks after the last owning input falls. The delay is the same for every channel.
- R3: `addr_o` bit i stands for channel i. It is loaded with the owning channels only in the cycle a hit starts and holds its value at all other times.
- R4: A rising edge on a non-owning channel after a hit has started and before `block_i` is released sets that channel's `pileup_o` bit SYNC_STAGES+1 clocks later. It leaves `hit_o` and `addr_o` unchanged.
- R5: A new pulse on the owning channel inside the pileup window never sets that channel's own `pileup_o` bit and does not alter `addr_o`.
- R6: After a hit ends, no further hit is issued until `block_i` has been seen high and then low. A channel that is still high when `block_i` is released is not forwarded; it needs a fresh rising edge.
- R7: While idle with `block_i` high, rising inputs produce no hit on `hit_o`.
- R8: A one-clock pulse on `pileup_clr_i` clears `pileup_o` on the next clock edge. An input that stays high through the clear does not set its bit again.
- R9: Channels whose rising edges reach the sampler in the same clock all become owners, and their `addr_o` bits are set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_i | input | NCH | Asynchronous discriminator pulse per channel |
| block_i | input | 1 | Hit-block control from the read-out controller |
| pileup_clr_i | input | 1 | Pileup clear pulse from the read-out controller |
| hit_o | output | 1 | Merged hit line following the owner's pulse |
| addr_o | output | NCH | One-hot owner address of the current or last hit |
| pileup_o | output | NCH | Channels that started a pulse during the pileup window |

## Verification
The bench runs every ordered pair of owner and intruder channels and every simultaneous pair. It checks for an equal rising and falling delay on each channel, which a design with uneven synchroniser depth would break. It checks that an intruder still high at block release is not forwarded as a truncated hit. It checks that a short owner re-pulse after the hit neither flags the owner as pileup nor disturbs the address, which is exactly what a design that latches the address from live inputs would get wrong. It also holds an intruder high across the pileup clear to catch a level-sensitive pileup register, which would re-set the bit and leave it stale for the next hit.

// File: rtl/hit_merge_pkg.sv
package hit_merge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ACK  = 2'd2,
    ST_REL  = 2'd3
  } merge_state_t;
endpackage

// File: rtl/hit_merge_sync.sv
module hit_merge_sync #(
  parameter int NCH         = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pix_i,
  output logic [NCH-1:0] lvl_o,
  output logic [NCH-1:0] rise_o
);
  // Every channel gets an identical chain so that the delay is uniform.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SYNC_STAGES-1:0] sh_q;
    logic [SYNC_STAGES:0]   sh_wide;
    logic                   last_q;

    assign sh_wide = {sh_q, pix_i[c]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        last_q <= 1'b0;
      end else begin
        sh_q   <= sh_wide[SYNC_STAGES-1:0];
        last_q <= sh_q[SYNC_STAGES-1];
      end
    end

    assign lvl_o[c]  = sh_q[SYNC_STAGES-1];
    assign rise_o[c] = sh_q[SYNC_STAGES-1] & ~last_q;
  end
endmodule

// File: rtl/hit_merge_ctrl.sv
module hit_merge_ctrl
  import hit_merge_pkg::*;
#(
  parameter int NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] lvl_i,
  input  logic [NCH-1:0] rise_i,
  input  logic           block_i,
  output logic           hit_o,
  output logic [NCH-1:0] addr_o,
  output logic [NCH-1:0] owner_o,
  output logic           win_o
);
  merge_state_t   state_q, state_d;
  logic [NCH-1:0] owner_q, owner_d;
  logic [NCH-1:0] addr_q, addr_d;
  logic           hit_q, hit_d;

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    addr_d  = addr_q;
    hit_d   = hit_q;
    unique case (state_q)
      ST_IDLE: if (!block_i && (|rise_i)) begin
        state_d = ST_BUSY;
        owner_d = rise_i;
        addr_d  = rise_i;
        hit_d   = 1'b1;
      end
      ST_BUSY: if ((lvl_i & owner_q) == '0) begin
        state_d = ST_ACK;
        hit_d   = 1'b0;
      end
      ST_ACK:  if (block_i)  state_d = ST_REL;
      ST_REL:  if (!block_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      addr_q  <= '0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
      addr_q  <= addr_d;
      hit_q   <= hit_d;
    end
  end

  assign hit_o   = hit_q;
  assign addr_o  = addr_q;
  assign owner_o = owner_q;
  assign win_o   = (state_q != ST_IDLE);

  // R7: a blocked, quiet line stays quiet
  a_r7_block_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (block_i && !hit_o) |=> !hit_o);
  // R3: address only moves when a hit starts
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(hit_o) |-> $stable(addr_o));
  // R3: a started hit always names an owner
  a_r3_addr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_o) |-> (addr_o != '0));
  // R6: a hit only starts from a fresh edge
  a_r6_fresh_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_o) |-> $past(|rise_i));
endmodule

// File: rtl/hit_merge_pileup.sv
module hit_merge_pileup #(
  parameter int NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rise_i,
  input  logic [NCH-1:0] owner_i,
  input  logic           win_i,
  input  logic           clr_i,
  output logic [NCH-1:0] pileup_o
);
  logic [NCH-1:0] pile_q, pile_d, set_vec;

  always_comb begin
    set_vec = win_i ? (rise_i & ~owner_i) : '0;
    pile_d  = (pile_q & ~{NCH{clr_i}}) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pile_q <= '0;
    else        pile_q <= pile_d;
  end

  assign pileup_o = pile_q;

  // R5: the owner never flags itself
  a_r5_no_self_pileup: assert property (@(posedge clk) disable iff (!rst_n)
    ((pile_q & ~$past(pile_q) & owner_i) == '0));
  // R8: after a clear only fresh edges survive
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((pile_q & $past(pile_q) & ~$past(rise_i)) == '0));
  // R4: bits appear only inside the window
  a_r4_set_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !win_i |=> ((pile_q & ~$past(pile_q)) == '0));
endmodule

// File: rtl/hit_merge_arbiter.sv
module hit_merge_arbiter #(
  parameter int NCH         = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pix_i,
  input  logic           block_i,
  input  logic           pileup_clr_i,
  output logic           hit_o,
  output logic [NCH-1:0] addr_o,
  output logic [NCH-1:0] pileup_o
);
  logic [NCH-1:0] lvl, rise, owner;
  logic           win;

  hit_merge_sync #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .lvl_o(lvl), .rise_o(rise)
  );

  hit_merge_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_i(rise), .block_i(block_i),
    .hit_o(hit_o), .addr_o(addr_o), .owner_o(owner), .win_o(win)
  );

  hit_merge_pileup #(.NCH(NCH)) u_pile (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .owner_i(owner), .win_i(win),
    .clr_i(pileup_clr_i), .pileup_o(pileup_o)
  );
endmodule

// File: tb/hit_merge_arbiter_bench.sv
module hit_merge_arbiter_bench;
  localparam int NCH = 5;
  localparam int SYNC = 2;
  localparam int L = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] pix;
  logic block, clr;
  logic hit;
  logic [NCH-1:0] addr, pile;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hit_merge_arbiter #(.NCH(NCH), .SYNC_STAGES(SYNC)) u_hit_merge_arbiter (
    .clk(clk), .rst_n(rst_n), .pix_i(pix), .block_i(block),
    .pileup_clr_i(clr), .hit_o(hit), .addr_o(addr), .pileup_o(pile)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix = '0; block = 1'b0; clr = 1'b0;
    tick(3);
    chk("R1 hit", {31'd0, hit}, 0);
    chk("R1 addr", {27'd0, addr}, 0);
    chk("R1 pileup", {27'd0, pile}, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 after release", {26'd0, hit, addr}, 0);

    // owner / intruder sweep
    for (int ch = 0; ch < NCH; ch++) begin
      for (int j = 0; j < NCH; j++) begin
        if (j == ch) continue;
        pix[ch] = 1'b1;
        tick(L - 1);
        chk("R2 rise not early", {31'd0, hit}, 0);
        tick(1);
        chk("R2 rise delay", {31'd0, hit}, 1);
        chk("R3 owner address", {27'd0, addr}, 32'd1 << ch);
        pix[j] = 1'b1;
        tick(L);
        chk("R4 pileup set", {27'd0, pile}, 32'd1 << j);
        chk("R4 hit kept", {31'd0, hit}, 1);
        chk("R4 addr kept", {27'd0, addr}, 32'd1 << ch);
        pix[ch] = 1'b0;
        tick(L - 1);
        chk("R2 fall not early", {31'd0, hit}, 1);
        tick(1);
        chk("R2 fall delay", {31'd0, hit}, 0);
        pix[ch] = 1'b1;
        tick(1);
        pix[ch] = 1'b0;
        tick(L + 1);
        chk("R5 no self pileup", {27'd0, pile}, 32'd1 << j);
        chk("R5 addr after spike", {27'd0, addr}, 32'd1 << ch);
        chk("R6 no hit before release", {31'd0, hit}, 0);
        block = 1'b1;
        tick(2);
        block = 1'b0;
        tick(L + 3);
        chk("R6 held input not forwarded", {31'd0, hit}, 0);
        chk("R3 addr held", {27'd0, addr}, 32'd1 << ch);
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        chk("R8 cleared", {27'd0, pile}, 0);
        tick(L + 2);
        chk("R8 no stale bit", {27'd0, pile}, 0);
        pix[j] = 1'b0;
        tick(L + 2);
        chk("R6 quiet after drop", {31'd0, hit}, 0);
      end
    end

    // simultaneous pairs
    for (int a = 0; a < NCH; a++) begin
      for (int b = a + 1; b < NCH; b++) begin
        pix = NCH'((32'd1 << a) | (32'd1 << b));
        tick(L);
        chk("R9 hit", {31'd0, hit}, 1);
        chk("R9 both address bits", {27'd0, addr}, (32'd1 << a) | (32'd1 << b));
        chk("R9 no pileup", {27'd0, pile}, 0);
        pix = '0;
        tick(L);
        chk("R2 pair fall", {31'd0, hit}, 0);
        block = 1'b1;
        tick(2);
        block = 1'b0;
        tick(3);
      end
    end

    // blocked while idle
    block = 1'b1;
    tick(1);
    for (int k = 0; k < NCH; k++) begin
      pix[k] = 1'b1;
      tick(L + 1);
      chk("R7 blocked idle", {31'd0, hit}, 0);
      pix[k] = 1'b0;
      tick(L);
    end
    pix[1] = 1'b1;
    tick(L + 1);
    block = 1'b0;
    tick(L + 2);
    chk("R7 held through release", {31'd0, hit}, 0);
    chk("R3 addr untouched", {27'd0, addr}, (32'd1 << 3) | (32'd1 << 4));
    pix[1] = 1'b0;
    tick(L);
    pix[2] = 1'b1;
    tick(L);
    chk("R6 re-armed", {31'd0, hit}, 1);
    chk("R3 new owner", {27'd0, addr}, 32'd4);
    pix[2] = 1'b0;
    tick(L + 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule